// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block brings a hung I2C bus back to the idle state before the main bus controller is initialised again. A one-cycle request starts a recovery run. For the whole run the block holds the controller in reset and leaves both bus lines released. It then samples the bus. The bus counts as free only when SCL and SDA both read high. If the bus is not free, the block pulls SCL low for a fixed time and then releases it. These pulses clock out a slave device that is holding SDA low partway through a byte.

The loop has a fixed limit. Every iteration starts with a free check, and the run ends at the first check that finds the bus free. If the bus is still busy after the iteration limit, the run ends as a failure. In both cases the block drops the controller reset, raises a one-cycle completion pulse and reports the outcome on a status flag. The block never drives SDA, never generates a STOP condition and never touches controller registers. Software or a supervisor then re-initialises the controller.

The two bus inputs pass through two-flop synchronisers. After each SCL release the block waits a programmable settle time before the next free check, so that the line has time to rise.

Top module: `i2c_bus_recovery`

## Requirements
- R1: `ctrl_rst_o` goes high in the cycle after an accepted request. It stays high for the whole run and falls in the same cycle that `done_o` rises, whether the run succeeded or failed. `scl_rel_o` is low only while `ctrl_rst_o` is high.
- R2: The bus is treated as free only when the synchronised SCL and SDA are both high (1). A low on either line alone makes the bus busy. Each input passes through two flip-flops before it is used.
- R3: If the bus is free at the first check, the run completes with zero SCL pulses and `ok_o` = 1.
- R4: Every iteration checks for a free bus before it pulses. The number of SCL pulses in a run equals the number of pulses the stuck slave needs before it releases SDA, provided that number does not exceed `MAX_ITER`.
- R5: Each SCL pulse keeps `scl_rel_o` low (0 = pull SCL low, 1 = release) for exactly `PULSE_CYC` clock cycles.
- R6: After each release of SCL, `scl_rel_o` stays high for at least `SETTLE_CYC` cycles before the next pulse or the completion pulse.
- R7: A run makes at most `MAX_ITER` pulses. If the bus is still busy when the limit is reached, the run completes with `ok_o` = 0.
- R8: `done_o` is high for exactly one cycle per run. `ok_o` is 1 when the bus was free at exit and 0 after a failed run. `ok_o` holds its value until the next accepted request.
- R9: `sda_rel_o` is always 1, so the block never pulls SDA low.
- R10: A request that arrives while a run is in progress is ignored. It adds no pulse and causes no second completion.
- R11: After reset `ctrl_rst_o`, `done_o` and `ok_o` are 0, and `scl_rel_o` and `sda_rel_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle recovery request |
| scl_i | input | 1 | Sampled SCL line level (asynchronous) |
| sda_i | input | 1 | Sampled SDA line level (asynchronous) |
| scl_rel_o | output | 1 | 1 = release SCL, 0 = pull SCL low |
| sda_rel_o | output | 1 | SDA release enable, always 1 |
| ctrl_rst_o | output | 1 | Holds the main controller in reset during recovery |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | 1 = bus recovered, 0 = recovery failed; valid from `done_o` onward |

## Verification
The assertions assume three things about the inputs. `req_i` is a one-cycle strobe. Reset is applied from time zero. The bus lines may change at any time, because they are synchronised before use.

The stimulus models a slave that holds SDA low until it has seen a set number of SCL rising edges on the wired line. A separate case holds SCL low from outside to give a permanently stuck bus. Bus levels are only changed between clock edges and a few cycles before a request, so the first free check always sees settled values.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHECK  = 2'd1,
    ST_PULSE  = 2'd2,
    ST_SETTLE = 2'd3
  } rcv_state_t;

endpackage

// File: rtl/rcv_sync.sv
module rcv_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;  // idle bus reads high
      else     chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/rcv_timer.sv
module rcv_timer #(
  parameter int MAX_LOAD = 2500,
  localparam int W = $clog2(MAX_LOAD + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R5
  timer_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= W'(MAX_LOAD));

endmodule

// File: rtl/rcv_seq.sv
module rcv_seq
  import i2c_rcv_pkg::*;
#(
  parameter int PULSE_CYC  = 2500,
  parameter int SETTLE_CYC = 250,
  parameter int MAX_ITER   = 100,
  localparam int TMR_MAX   = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC,
  localparam int TW        = $clog2(TMR_MAX + 1),
  localparam int IW        = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          tmr_exp,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          scl_rel,
  output logic          ctrl_rst,
  output logic          done,
  output logic          ok
);

  rcv_state_t    state;
  logic [IW-1:0] iter;
  logic          bus_free;
  logic          at_limit;

  assign bus_free = scl_s & sda_s;
  assign at_limit = (iter == IW'(MAX_ITER));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state == ST_CHECK && !bus_free && !at_limit) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(PULSE_CYC - 1);
    end else if (state == ST_PULSE && tmr_exp) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(SETTLE_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      iter     <= '0;
      scl_rel  <= 1'b1;
      ctrl_rst <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            ctrl_rst <= 1'b1;
            ok       <= 1'b0;
            iter     <= '0;
            state    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (bus_free || at_limit) begin
            done     <= 1'b1;
            ctrl_rst <= 1'b0;
            ok       <= bus_free;
            state    <= ST_IDLE;
          end else begin
            scl_rel <= 1'b0;
            state   <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          if (tmr_exp) begin
            scl_rel <= 1'b1;
            iter    <= iter + 1'b1;
            state   <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tmr_exp) state <= ST_CHECK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  fell_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_rst) |-> done);

  // R1
  scl_only_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !scl_rel |-> ctrl_rst);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
    iter <= IW'(MAX_ITER));

  // R3
  free_first_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHECK && scl_s && sda_s) |=> (done && ok && scl_rel));

  // R5
  pulse_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_rel) |-> $past(tmr_exp));

endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery #(
  parameter int PULSE_CYC  = 2500,
  parameter int SETTLE_CYC = 250,
  parameter int MAX_ITER   = 100,
  parameter int SYNC_STAGES = 2,
  localparam int TMR_MAX   = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC,
  localparam int TW        = $clog2(TMR_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rel_o,
  output logic sda_rel_o,
  output logic ctrl_rst_o,
  output logic done_o,
  output logic ok_o
);

  logic [1:0]    line_s;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_exp;

  rcv_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sda_i, scl_i}),
    .q   (line_s)
  );

  rcv_timer #(.MAX_LOAD(TMR_MAX)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  rcv_seq #(
    .PULSE_CYC  (PULSE_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .MAX_ITER   (MAX_ITER)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req_i),
    .scl_s    (line_s[0]),
    .sda_s    (line_s[1]),
    .tmr_exp  (tmr_exp),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .scl_rel  (scl_rel_o),
    .ctrl_rst (ctrl_rst_o),
    .done     (done_o),
    .ok       (ok_o)
  );

  assign sda_rel_o = 1'b1;

endmodule

// File: tb/i2c_bus_recovery_tb.sv
`timescale 1ns/1ps
module i2c_bus_recovery_tb;

  localparam int P  = 20;
  localparam int S  = 6;
  localparam int MI = 100;
  localparam int NV = 9;

  // slave hold count, SCL stuck low externally, expected pulses, expected ok
  localparam int VK   [NV] = '{0, 1, 5, 9, 99, 100, 101, 200, 0};
  localparam int VST  [NV] = '{0, 0, 0, 0, 0,  0,   0,   0,   1};
  localparam int VEP  [NV] = '{0, 1, 5, 9, 99, 100, 100, 100, 100};
  localparam int VOK  [NV] = '{1, 1, 1, 1, 1,  1,   0,   0,   0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic slave_sda = 1'b1;
  logic scl_stuck = 1'b0;
  logic scl_rel, sda_rel, ctrl_rst, done, ok;
  logic scl_line, sda_line;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  assign scl_line = scl_rel & ~scl_stuck;
  assign sda_line = sda_rel & slave_sda;

  i2c_bus_recovery #(.PULSE_CYC(P), .SETTLE_CYC(S), .MAX_ITER(MI)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req),
    .scl_i      (scl_line),
    .sda_i      (sda_line),
    .scl_rel_o  (scl_rel),
    .sda_rel_o  (sda_rel),
    .ctrl_rst_o (ctrl_rst),
    .done_o     (done),
    .ok_o       (ok)
  );

  task automatic check(input bit cond, input string req_tag, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // Runs one recovery; optional extra request at cycle extra_at (0 = none)
  task automatic run_case(input int k, input bit stuck, input int exp_p,
                          input bit exp_ok, input int extra_at);
    int  pulses = 0, rel_cnt = 0, low_w = 0, high_w = 0, cyc = 0;
    int  bad_w = 0, bad_gap = 0, bad_rst = 0, bad_sda = 0, dones = 0;
    bit  prev = 1'b1;
    bit  saw_rst = 1'b0;
    scl_stuck = stuck;
    slave_sda = (k == 0);
    repeat (5) @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    // R1: reset asserted in cycle after request
    check(ctrl_rst === 1'b1, "R1 ctrl_rst after req", ctrl_rst, 1);
    while (dones == 0 && cyc < 20000) begin
      cyc++;
      if (extra_at != 0 && cyc == extra_at) req = 1'b1;
      else req = 1'b0;
      if (sda_rel !== 1'b1) bad_sda++;
      if (done) begin
        dones++;
        if (ctrl_rst !== 1'b0) bad_rst++;
        if (high_w < S && pulses > 0) bad_gap++;
      end else if (ctrl_rst !== 1'b1) bad_rst++;
      if (!scl_rel) begin
        if (prev) begin
          pulses++;
          if (pulses > 1 && high_w < S) bad_gap++;
        end
        low_w++;
        high_w = 0;
      end else begin
        if (!prev) begin
          if (low_w != P) bad_w++;
          if (!stuck) rel_cnt++;
        end
        low_w = 0;
        high_w++;
      end
      prev = scl_rel;
      slave_sda = (rel_cnt >= k);
      if (dones == 0) @(negedge clk);
    end
    req = 1'b0;
    check(dones == 1, "R8 done seen", dones, 1);
    check(pulses == exp_p, (exp_p == MI) ? "R7 pulse limit" : ((k == 0) ? "R3 no pulses when free" : "R4 pulse count"), pulses, exp_p);
    check(ok === exp_ok, exp_ok ? "R8 ok recovered" : "R7 ok failed", ok, exp_ok);
    check(bad_w == 0, "R5 pulse width", bad_w, 0);
    check(bad_gap == 0, "R6 settle gap", bad_gap, 0);
    check(bad_rst == 0, "R1 ctrl_rst span", bad_rst, 0);
    check(bad_sda == 0, "R9 sda released", bad_sda, 0);
    // done lasts one cycle, ok held
    @(negedge clk);
    check(done === 1'b0, "R8 done one cycle", done, 0);
    repeat (20) @(negedge clk);
    check(ok === exp_ok, "R8 ok held", ok, exp_ok);
    check(ctrl_rst === 1'b0 && scl_rel === 1'b1, "R10 idle after run", ctrl_rst, 0);
  endtask

  initial begin
    #(4.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    check(ctrl_rst === 1'b0 && done === 1'b0 && ok === 1'b0, "R11 reset outputs low", {ctrl_rst, done, ok}, 0);
    check(scl_rel === 1'b1 && sda_rel === 1'b1, "R11 lines released", {scl_rel, sda_rel}, 3);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_case(VK[i], VST[i], VEP[i], VOK[i], 0);
    end

    // R2: SCL high, SDA low alone counts busy; SDA high but SCL stuck counted above
    run_case(2, 1'b0, 2, 1'b1, 0);

    // R10: repeated request mid-run is ignored
    run_case(3, 1'b0, 3, 1'b1, 30);

    // R8: ok cleared by a new request, then fail result
    run_case(150, 1'b0, 100, 1'b0, 0);
    run_case(0, 1'b0, 0, 1'b1, 0);

    // R11: synchronous reset mid-run returns to idle state
    scl_stuck = 1'b1;
    repeat (4) @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(ctrl_rst === 1'b0 && scl_rel === 1'b1 && ok === 1'b0, "R11 reset mid-run", ctrl_rst, 0);
    rst = 1'b0;
    scl_stuck = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule